// File: doc/BRIEF.md
# Programmer-Visible Register File with Paired Accumulators

This block holds the working registers of a small 16-bit-address processor core. It has two byte-wide accumulators, called A and B, and it treats them together as one 16-bit accumulator D. A sits in the upper byte of D and B in the lower byte. The block also has three 16-bit pointer registers (X, Y and the stack pointer SP), a 16-bit program counter (PC) and a byte-wide flag register (CCR). The control logic around the block decides which registers are written in a cycle, and it does so through one load strobe per register. The new flag value is computed elsewhere and arrives on its own input.

Beyond plain loads, the block can clear either accumulator, can exchange A and B in one clock, and can step the PC by one or two. The carry out of that step is visible on an output, so a wrap through the top of the address space can be seen. Two independent 16-bit read ports, each with a 3-bit selector, feed the arithmetic unit and the internal bus.

Top module: `progreg_file`

## Requirements
- R1: While `rst_n` is low at a rising edge, A, B, X, Y and CCR become zero, SP takes `sp_rst_val` and PC takes `pc_rst_val`.
- R2: D is not separate storage. Reading D returns {A, B}, and `ld_d` writes `acc_din[15:8]` into A and `acc_din[7:0]` into B in the same edge.
- R3: `ld_a` writes `acc_din[7:0]` into A only, and `ld_b` writes `acc_din[7:0]` into B only. The other half of D keeps its value.
- R4: `clr_a` forces A to zero at the next edge, and `clr_b` does the same for B. A clear wins over any load or exchange on that accumulator.
- R5: `swap_ab` exchanges A and B in one edge. On either half, a load of that half takes precedence over the exchange, while the other half still receives the old value of its partner.
- R6: X, Y and SP each load `idx_din` on their own strobe (`ld_x`, `ld_y`, `ld_sp`). A register whose strobe is low keeps its value.
- R7: `ld_ccr` writes `ccr_din` into CCR at the next edge. Otherwise CCR holds.
- R8: With `pc_inc` high, PC advances by 2 if `pc_inc_two` is high and by 1 otherwise. `ld_pc` loads `pc_din` and takes precedence over the step.
- R9: `pc_carry` is high exactly when `pc_inc` is high and the step overflows 16 bits. The PC wraps modulo 2^16: FFFF+1 gives 0000 and FFFE+2 gives 0000.
- R10: Each read port shows the register its selector names. The encoding is 0=A, 1=B, 2=D, 3=X, 4=Y, 5=SP, 6=PC, 7=CCR. Byte registers appear zero-extended in bits 15:8. The two ports act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sp_rst_val | input | 16 | Value SP takes during reset |
| pc_rst_val | input | 16 | Value PC takes during reset |
| acc_din | input | 16 | Accumulator write data |
| ld_a | input | 1 | Load A from acc_din[7:0] |
| ld_b | input | 1 | Load B from acc_din[7:0] |
| ld_d | input | 1 | Load A:B from acc_din |
| clr_a | input | 1 | Clear A |
| clr_b | input | 1 | Clear B |
| swap_ab | input | 1 | Exchange A and B |
| idx_din | input | 16 | Pointer register write data |
| ld_x | input | 1 | Load X |
| ld_y | input | 1 | Load Y |
| ld_sp | input | 1 | Load SP |
| ccr_din | input | 8 | New flag byte |
| ld_ccr | input | 1 | Load CCR |
| pc_din | input | 16 | PC parallel load value |
| ld_pc | input | 1 | Load PC |
| pc_inc | input | 1 | Step PC |
| pc_inc_two | input | 1 | Step size 2 instead of 1 |
| pc_carry | output | 1 | Carry out of the PC step |
| rsel_a | input | 3 | Read port A selector |
| rsel_b | input | 3 | Read port B selector |
| rdata_a | output | 16 | Read port A data |
| rdata_b | output | 16 | Read port B data |

## Verification
The bench builds the block with the default byte width of 8, which gives 16-bit pointers and PC. At that width, both wrap cases of the PC step (FFFF+1 and FFFE+2) can be reached with one parallel load and a single step. The byte width also fixes the zero-extension boundary at bit 8, so each byte register is read back on a full-width port to show that its upper half is clear. Priority collisions are driven in single cycles: clear against load, clear against exchange, load against exchange, and load against step.

// File: rtl/prf_pkg.sv
// Shared definitions for the register file: read-port selector codes.
// Assumes a 3-bit selector; the codes are fixed because the decoder
// around the block issues them.
package prf_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_A   = 3'd0,
        SEL_B   = 3'd1,
        SEL_D   = 3'd2,
        SEL_X   = 3'd3,
        SEL_Y   = 3'd4,
        SEL_SP  = 3'd5,
        SEL_PC  = 3'd6,
        SEL_CCR = 3'd7
    } rsel_e;
endpackage

// File: rtl/prf_acc_pair.sv
// Accumulator pair A (upper byte) and B (lower byte). Together they form D.
// Per-half priority: clear, then load (D or the single half), then exchange.
// Assumes the control logic may raise any mix of strobes in one cycle.
module prf_acc_pair #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_a,
    input  logic                  ld_b,
    input  logic                  ld_d,
    input  logic                  clr_a,
    input  logic                  clr_b,
    input  logic                  swap,
    input  logic [2*BYTE_W-1:0]   din,
    output logic [BYTE_W-1:0]     a_q,
    output logic [BYTE_W-1:0]     b_q
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] a_nxt;
    logic [BYTE_W-1:0] b_nxt;

    // Next value of A by priority.
    always_comb begin
        if (clr_a)      a_nxt = '0;
        else if (ld_d)  a_nxt = din[WORD_W-1:BYTE_W];
        else if (ld_a)  a_nxt = din[BYTE_W-1:0];
        else if (swap)  a_nxt = b_q;
        else            a_nxt = a_q;
    end

    // Next value of B by priority.
    always_comb begin
        if (clr_b)      b_nxt = '0;
        else if (ld_d)  b_nxt = din[BYTE_W-1:0];
        else if (ld_b)  b_nxt = din[BYTE_W-1:0];
        else if (swap)  b_nxt = a_q;
        else            b_nxt = b_q;
    end

    // Accumulator storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_nxt;
            b_q <= b_nxt;
        end
    end

    AST_CLR_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_a |=> (a_q == '0)); // R4
    AST_CLR_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_b |=> (b_q == '0)); // R4
    AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !clr_a && !clr_b && !ld_a && !ld_b && !ld_d)
        |=> (a_q == $past(b_q)) && (b_q == $past(a_q))); // R5
    AST_A_ONLY_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a && !ld_b && !ld_d && !clr_b && !swap) |=> $stable(b_q)); // R3
endmodule

// File: rtl/prf_word_reg.sv
// Generic word-wide register with its own load strobe and a reset value
// that comes in from outside. Used for the X, Y and SP pointers.
module prf_word_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rst_val,
    input  logic              ld,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] q
);
    // Hold or load the word.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= rst_val;
        else if (ld)  q <= din;
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q)); // R6
endmodule

// File: rtl/prf_pc_unit.sv
// Program counter with a +1/+2 incrementer and a parallel load.
// A parallel load beats the step. The carry reports an overflow of the
// step whenever stepping is requested.
module prf_pc_unit #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rst_val,
    input  logic              ld,
    input  logic [WORD_W-1:0] load_val,
    input  logic              inc_en,
    input  logic              inc_two,
    output logic              carry_o,
    output logic [WORD_W-1:0] pc_q
);
    logic [WORD_W-1:0] step;
    logic [WORD_W:0]   sum;

    // Incrementer: add the step size with a carry bit.
    always_comb begin
        step    = inc_two ? WORD_W'(2) : WORD_W'(1);
        sum     = {1'b0, pc_q} + {1'b0, step};
        carry_o = inc_en & sum[WORD_W];
    end

    // PC source selection and storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= rst_val;
        else if (ld)      pc_q <= load_val;
        else if (inc_en)  pc_q <= sum[WORD_W-1:0];
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (pc_q == $past(load_val))); // R8
    AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_o && !ld) |=> (pc_q[WORD_W-1:1] == '0)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc_en) |=> $stable(pc_q)); // R8
endmodule

// File: rtl/prf_read_mux.sv
// One read port. It picks a register by the selector code from prf_pkg and
// zero-extends the byte registers to the full port width.
module prf_read_mux #(
    parameter int BYTE_W = 8
) (
    input  logic [prf_pkg::SEL_W-1:0] sel,
    input  logic [BYTE_W-1:0]         a,
    input  logic [BYTE_W-1:0]         b,
    input  logic [2*BYTE_W-1:0]       x,
    input  logic [2*BYTE_W-1:0]       y,
    input  logic [2*BYTE_W-1:0]       sp,
    input  logic [2*BYTE_W-1:0]       pc,
    input  logic [BYTE_W-1:0]         ccr,
    output logic [2*BYTE_W-1:0]       dout
);
    import prf_pkg::*;
    localparam logic [BYTE_W-1:0] ZPAD = '0;

    // Selector decode.
    always_comb begin
        case (rsel_e'(sel))
            SEL_A:   dout = {ZPAD, a};
            SEL_B:   dout = {ZPAD, b};
            SEL_D:   dout = {a, b};
            SEL_X:   dout = x;
            SEL_Y:   dout = y;
            SEL_SP:  dout = sp;
            SEL_PC:  dout = pc;
            SEL_CCR: dout = {ZPAD, ccr};
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/progreg_file.sv
// Top of the register file: the accumulator pair, three pointer registers
// built by a generate loop, the PC unit, CCR storage and two read ports.
// Assumes the flag byte is computed outside and comes in on ccr_din.
module progreg_file #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-1:0]         sp_rst_val,
    input  logic [WORD_W-1:0]         pc_rst_val,
    input  logic [WORD_W-1:0]         acc_din,
    input  logic                      ld_a,
    input  logic                      ld_b,
    input  logic                      ld_d,
    input  logic                      clr_a,
    input  logic                      clr_b,
    input  logic                      swap_ab,
    input  logic [WORD_W-1:0]         idx_din,
    input  logic                      ld_x,
    input  logic                      ld_y,
    input  logic                      ld_sp,
    input  logic [BYTE_W-1:0]         ccr_din,
    input  logic                      ld_ccr,
    input  logic [WORD_W-1:0]         pc_din,
    input  logic                      ld_pc,
    input  logic                      pc_inc,
    input  logic                      pc_inc_two,
    output logic                      pc_carry,
    input  logic [prf_pkg::SEL_W-1:0] rsel_a,
    input  logic [prf_pkg::SEL_W-1:0] rsel_b,
    output logic [WORD_W-1:0]         rdata_a,
    output logic [WORD_W-1:0]         rdata_b
);
    localparam int NUM_IDX = 3;  // X, Y, SP
    localparam int IDX_SP  = 2;

    logic [BYTE_W-1:0]               a_q, b_q, ccr_q;
    logic [WORD_W-1:0]               pc_q;
    logic [NUM_IDX-1:0]              idx_ld;
    logic [NUM_IDX-1:0][WORD_W-1:0]  idx_rst;
    logic [NUM_IDX-1:0][WORD_W-1:0]  idx_q;

    // Gather pointer strobes and reset values in index order.
    always_comb begin
        idx_ld          = {ld_sp, ld_y, ld_x};
        idx_rst         = '0;
        idx_rst[IDX_SP] = sp_rst_val;
    end

    prf_acc_pair #(.BYTE_W(BYTE_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_a  (ld_a),
        .ld_b  (ld_b),
        .ld_d  (ld_d),
        .clr_a (clr_a),
        .clr_b (clr_b),
        .swap  (swap_ab),
        .din   (acc_din),
        .a_q   (a_q),
        .b_q   (b_q)
    );

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        prf_word_reg #(.WORD_W(WORD_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (idx_rst[g]),
            .ld      (idx_ld[g]),
            .din     (idx_din),
            .q       (idx_q[g])
        );
    end

    prf_pc_unit #(.WORD_W(WORD_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_val  (pc_rst_val),
        .ld       (ld_pc),
        .load_val (pc_din),
        .inc_en   (pc_inc),
        .inc_two  (pc_inc_two),
        .carry_o  (pc_carry),
        .pc_q     (pc_q)
    );

    // Flag byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ccr_q <= '0;
        else if (ld_ccr)  ccr_q <= ccr_din;
    end

    prf_read_mux #(.BYTE_W(BYTE_W)) u_rd_a (
        .sel (rsel_a), .a (a_q), .b (b_q), .x (idx_q[0]), .y (idx_q[1]),
        .sp (idx_q[IDX_SP]), .pc (pc_q), .ccr (ccr_q), .dout (rdata_a)
    );

    prf_read_mux #(.BYTE_W(BYTE_W)) u_rd_b (
        .sel (rsel_b), .a (a_q), .b (b_q), .x (idx_q[0]), .y (idx_q[1]),
        .sp (idx_q[IDX_SP]), .pc (pc_q), .ccr (ccr_q), .dout (rdata_b)
    );

    AST_CCR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ccr |=> (ccr_q == $past(ccr_din))); // R7
    AST_D_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_d && !clr_a && !clr_b) |=> ({a_q, b_q} == $past(acc_din))); // R2
endmodule

// File: tb/progreg_file_tb.sv
`timescale 1ns/1ps
module progreg_file_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] sp_rst_val, pc_rst_val, acc_din, idx_din, pc_din;
    logic        ld_a, ld_b, ld_d, clr_a, clr_b, swap_ab;
    logic        ld_x, ld_y, ld_sp, ld_ccr, ld_pc, pc_inc, pc_inc_two;
    logic [7:0]  ccr_din;
    logic        pc_carry;
    logic [2:0]  rsel_a, rsel_b;
    logic [15:0] rdata_a, rdata_b;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    progreg_file u_dut (
        .clk(clk), .rst_n(rst_n), .sp_rst_val(sp_rst_val), .pc_rst_val(pc_rst_val),
        .acc_din(acc_din), .ld_a(ld_a), .ld_b(ld_b), .ld_d(ld_d),
        .clr_a(clr_a), .clr_b(clr_b), .swap_ab(swap_ab),
        .idx_din(idx_din), .ld_x(ld_x), .ld_y(ld_y), .ld_sp(ld_sp),
        .ccr_din(ccr_din), .ld_ccr(ld_ccr), .pc_din(pc_din), .ld_pc(ld_pc),
        .pc_inc(pc_inc), .pc_inc_two(pc_inc_two), .pc_carry(pc_carry),
        .rsel_a(rsel_a), .rsel_b(rsel_b), .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ld_a = 0; ld_b = 0; ld_d = 0; clr_a = 0; clr_b = 0; swap_ab = 0;
        ld_x = 0; ld_y = 0; ld_sp = 0; ld_ccr = 0; ld_pc = 0;
        pc_inc = 0; pc_inc_two = 0;
    endtask

    // One rising edge, then return at the falling edge with strobes cleared.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] v);
        rsel_a = s;
        #1;
        v = rdata_a;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst_n = 0; sp_rst_val = 16'h3FF0; pc_rst_val = 16'hC000;
        step(); step();
        rst_n = 1;
        rd(3'd0, v); chk("R1", "A after reset", v, 16'h0000);
        rd(3'd1, v); chk("R1", "B after reset", v, 16'h0000);
        rd(3'd3, v); chk("R1", "X after reset", v, 16'h0000);
        rd(3'd4, v); chk("R1", "Y after reset", v, 16'h0000);
        rd(3'd5, v); chk("R1", "SP after reset", v, 16'h3FF0);
        rd(3'd6, v); chk("R1", "PC after reset", v, 16'hC000);
        rd(3'd7, v); chk("R1", "CCR after reset", v, 16'h0000);
    endtask

    task automatic t_dload();
        logic [15:0] v;
        acc_din = 16'hA55A; ld_d = 1; step();
        rd(3'd0, v); chk("R2", "A from D load", v, 16'h00A5);
        rd(3'd1, v); chk("R2", "B from D load", v, 16'h005A);
        rd(3'd2, v); chk("R2", "D alias", v, 16'hA55A);
    endtask

    task automatic t_half();
        logic [15:0] v;
        acc_din = 16'hFF12; ld_a = 1; step();
        rd(3'd2, v); chk("R3", "D after A load", v, 16'h125A);
        acc_din = 16'hEE34; ld_b = 1; step();
        rd(3'd2, v); chk("R3", "D after B load", v, 16'h1234);
    endtask

    task automatic t_swap();
        logic [15:0] v;
        swap_ab = 1; step();
        rd(3'd2, v); chk("R5", "D after exchange", v, 16'h3412);
        swap_ab = 1; ld_a = 1; acc_din = 16'h0077; step();
        rd(3'd2, v); chk("R5", "load over exchange", v, 16'h7734);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        clr_a = 1; ld_a = 1; acc_din = 16'h0099; step();
        rd(3'd2, v); chk("R4", "clear A over load", v, 16'h0034);
        clr_b = 1; swap_ab = 1; step();
        rd(3'd2, v); chk("R4", "clear B over exchange", v, 16'h3400);
        clr_a = 1; clr_b = 1; ld_d = 1; acc_din = 16'hBEEF; step();
        rd(3'd2, v); chk("R4", "clear both over D load", v, 16'h0000);
    endtask

    task automatic t_index();
        logic [15:0] v;
        idx_din = 16'h1111; ld_x = 1; step();
        idx_din = 16'h2222; ld_y = 1; step();
        idx_din = 16'h3333; ld_sp = 1; step();
        idx_din = 16'h4444; step();
        rd(3'd3, v); chk("R6", "X keeps value", v, 16'h1111);
        rd(3'd4, v); chk("R6", "Y keeps value", v, 16'h2222);
        rd(3'd5, v); chk("R6", "SP loaded", v, 16'h3333);
    endtask

    task automatic t_ccr();
        logic [15:0] v;
        ccr_din = 8'hC5; ld_ccr = 1; step();
        rd(3'd7, v); chk("R7", "CCR loaded, zero-extended", v, 16'h00C5);
        ccr_din = 8'h3A; step();
        rd(3'd7, v); chk("R7", "CCR holds", v, 16'h00C5);
    endtask

    task automatic t_pc();
        logic [15:0] v;
        pc_inc = 1; step();
        rd(3'd6, v); chk("R8", "PC +1", v, 16'hC001);
        pc_inc = 1; pc_inc_two = 1; step();
        rd(3'd6, v); chk("R8", "PC +2", v, 16'hC003);
        pc_inc = 1; ld_pc = 1; pc_din = 16'h1234; step();
        rd(3'd6, v); chk("R8", "load over step", v, 16'h1234);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        pc_inc = 1; #1;
        chk("R9", "no carry mid-range", {15'd0, pc_carry}, 16'h0000);
        idle();
        pc_din = 16'hFFFF; ld_pc = 1; step();
        pc_inc = 1; #1;
        chk("R9", "carry at FFFF+1", {15'd0, pc_carry}, 16'h0001);
        step();
        rd(3'd6, v); chk("R9", "FFFF+1 wraps", v, 16'h0000);
        pc_din = 16'hFFFE; ld_pc = 1; step();
        pc_inc = 1; pc_inc_two = 1; #1;
        chk("R9", "carry at FFFE+2", {15'd0, pc_carry}, 16'h0001);
        step();
        rd(3'd6, v); chk("R9", "FFFE+2 wraps", v, 16'h0000);
        #1;
        chk("R9", "carry low without step", {15'd0, pc_carry}, 16'h0000);
    endtask

    task automatic t_ports();
        rsel_a = 3'd3; rsel_b = 3'd6; #1;
        chk("R10", "port A shows X", rdata_a, 16'h1111);
        chk("R10", "port B shows PC", rdata_b, 16'h0000);
        rsel_a = 3'd1; rsel_b = 3'd5; #1;
        chk("R10", "port A shows B zero-extended", rdata_a, 16'h0000);
        chk("R10", "port B shows SP", rdata_b, 16'h3333);
    endtask

    initial begin
        idle();
        acc_din = '0; idx_din = '0; pc_din = '0; ccr_din = '0;
        rsel_a = '0; rsel_b = '0;
        sp_rst_val = '0; pc_rst_val = '0; rst_n = 0;
        @(negedge clk);
        t_reset();
        t_dload();
        t_half();
        t_swap();
        t_clear();
        t_index();
        t_ccr();
        t_pc();
        t_wrap();
        t_ports();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule